// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns bytes written by a processor into asynchronous serial frames on one output line. A byte is presented on an 8-bit data bus together with a one-cycle write strobe. The block shifts it out as a low start bit, the eight data bits with the least significant bit first, and one or two high stop bits. Between frames the line rests high. Each bit lasts a whole number of clock cycles. That count is given directly as a divider parameter, or it is computed as clock frequency divided by bit rate when the divider is left at zero.

An optional first-in first-out queue of power-of-two depth can sit in front of the serializer. A clear-to-send input decides when a new frame may start. It can be ignored, active-high or active-low. Its level is checked only when a frame is about to begin, so a frame that has started always finishes. The busy output tells the writer when a write would be lost. Without the queue, busy covers both a frame in flight and a flow stop from the far end. With the queue, busy means the queue is full.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset the serial line is high, and it stays high whenever no frame is being sent.
- R2: A frame is one low start bit, then eight data bits with bit 0 first, each held for exactly the bit period in clock cycles.
- R3: Each frame ends with STOP_BITS (1 or 2) high bit periods before any following start bit.
- R4: CTS_MODE selects the clear-to-send sense: CTS_HIGH permits starts while the input is 1, CTS_LOW permits starts while it is 0, and CTS_NONE ignores the input. No frame starts while starts are not permitted.
- R5: Withdrawing clear-to-send during a frame does not cut or change that frame.
- R6: Without a queue (FIFO_DEPTH = 0), busy is 1 while a frame is in flight or while clear-to-send forbids starts. A write made while busy is dropped and never reaches the line.
- R7: With a queue, busy is 1 exactly when FIFO_DEPTH bytes are waiting. A write while busy is dropped, and queued bytes leave in the order they were written.
- R8: With BAUD_DIV = 0 the bit period is CLK_HZ / BAUD_HZ cycles. Otherwise it is BAUD_DIV cycles.
- R9: Parameters are checked when the design is built: STOP_BITS must be 1 or 2, FIFO_DEPTH must be 0 or a power of two of at least 2, and the bit period must be at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte to send |
| wr_stb | input | 1 | One-cycle write strobe |
| cts_in | input | 1 | Clear-to-send from the far end |
| busy | output | 1 | Writes are dropped while high |
| txd | output | 1 | Serial output line |

## Verification
Two events can land in the same cycle. One is the far end withdrawing clear-to-send while a frame is in flight. The other is the writer's strobe arriving while busy is high, either because a frame is running or because the queue is full. The bench drops clear-to-send partway through a frame and decodes the line to confirm the frame is intact and that nothing follows it. It also strobes a byte into a busy transmitter, both the unqueued one and the full queued one, and confirms that byte never shows up on the decoded line. It judges order and content against a queue of the bytes it expects to be accepted.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
   typedef enum logic [1:0] {
      CTS_NONE = 2'd0,
      CTS_HIGH = 2'd1,
      CTS_LOW  = 2'd2
   } cts_mode_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_push, do_pop;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= din;
   end

   // R7: a push into a full queue without a pop leaves the write pointer alone
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(wp));
   // R7: the queue never reports full and empty together
   p_full_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
   parameter int BIT_CYCLES = 8,
   parameter int STOP_BITS  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] din,
   input  logic       cts_ok,
   output logic       take,
   output logic       active,
   output logic       txd
);
   localparam int SLOTS = 9 + STOP_BITS;
   localparam int CW    = $clog2(BIT_CYCLES);
   localparam int SW    = $clog2(SLOTS);
   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
   localparam logic [CW-1:0] CMAX = CW'(BIT_CYCLES - 1);

   logic [CW-1:0]    cnt;
   logic [SW-1:0]    slot;
   logic [SLOTS-1:0] frame;
   logic             act_q, txd_q;

   assign take   = req && cts_ok && !act_q;
   assign active = act_q;
   assign txd    = txd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         txd_q <= 1'b1;
         cnt   <= '0;
         slot  <= '0;
         frame <= '1;
      end else if (take) begin
         act_q <= 1'b1;
         frame <= {{STOP_BITS{1'b1}}, din, 1'b0};
         txd_q <= 1'b0;
         cnt   <= CMAX;
         slot  <= '0;
      end else if (act_q) begin
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else if (slot == LAST) begin
            act_q <= 1'b0;
            txd_q <= 1'b1;
         end else begin
            slot  <= slot + 1'b1;
            frame <= {1'b1, frame[SLOTS-1:1]};
            txd_q <= frame[1];
            cnt   <= CMAX;
         end
      end
   end

   // R1: idle line is high
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> txd_q);
   // R2: the line holds within a bit period
   p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && cnt != '0) |=> $stable(txd_q));
   // R4: a frame begins only when starts were permitted
   p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(cts_ok));
   // R5: a frame never ends before its last slot
   p_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && slot != LAST) |=> act_q);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
   import uart_cts_tx_pkg::*;
#(
   parameter int        CLK_HZ     = 8_000_000,
   parameter int        BAUD_HZ    = 1_000_000,
   parameter int        BAUD_DIV   = 0,
   parameter int        STOP_BITS  = 1,
   parameter int        FIFO_DEPTH = 0,
   parameter cts_mode_e CTS_MODE   = CTS_NONE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] wr_data,
   input  logic       wr_stb,
   input  logic       cts_in,
   output logic       busy,
   output logic       txd
);
   localparam int BIT_CYCLES = (BAUD_DIV != 0) ? BAUD_DIV : (CLK_HZ / BAUD_HZ);

   // R9: build-time parameter checks
   initial begin
      a_stop_r9: assert (STOP_BITS == 1 || STOP_BITS == 2)
         else $fatal(1, "STOP_BITS must be 1 or 2");
      a_depth_r9: assert (FIFO_DEPTH == 0 || (FIFO_DEPTH >= 2 && is_pow2(FIFO_DEPTH)))
         else $fatal(1, "FIFO_DEPTH must be 0 or a power of two >= 2");
      a_period_r9: assert (BIT_CYCLES >= 2)
         else $fatal(1, "bit period must be at least 2 cycles");
   end

   logic       cts_ok;
   logic       req, take, active;
   logic [7:0] sdata;

   generate
      if (CTS_MODE == CTS_HIGH) begin : g_cts_hi
         assign cts_ok = cts_in;
      end else if (CTS_MODE == CTS_LOW) begin : g_cts_lo
         assign cts_ok = !cts_in;
      end else begin : g_cts_off
         assign cts_ok = 1'b1;
      end
   endgenerate

   generate
      if (FIFO_DEPTH == 0) begin : g_direct
         assign req   = wr_stb;
         assign sdata = wr_data;
         assign busy  = active || !cts_ok;

         // R6: a strobe while busy and idle does not start a frame
         p_drop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && busy && !active) |=> !active);
      end else begin : g_queued
         logic q_empty, q_full;

         uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (wr_stb),
            .din   (wr_data),
            .pop   (take),
            .dout  (sdata),
            .empty (q_empty),
            .full  (q_full)
         );

         assign req  = !q_empty;
         assign busy = q_full;

         // R7: the serializer only takes when bytes are waiting
         p_take_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            take |-> !q_empty);
      end
   endgenerate

   uart_tx_serializer #(.BIT_CYCLES(BIT_CYCLES), .STOP_BITS(STOP_BITS)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .din    (sdata),
      .cts_ok (cts_ok),
      .take   (take),
      .active (active),
      .txd    (txd)
   );
endmodule

// File: tb/sim_uart_cts_tx.sv
module sim_uart_cts_tx;
   import uart_cts_tx_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [7:0] wd0 = '0, wd1 = '0, wd2 = '0;
   logic       wr0 = 1'b0, wr1 = 1'b0, wr2 = 1'b0;
   logic       cts0 = 1'b0, cts1 = 1'b1, cts2 = 1'b0;
   logic       busy0, busy1, busy2, txd0, txd1, txd2;

   int n_tests = 0;
   int n_fail  = 0;

   // queued, two stop bits, active-low clear-to-send, 8-cycle bits
   uart_cts_tx #(.BAUD_DIV(8), .STOP_BITS(2), .FIFO_DEPTH(4), .CTS_MODE(CTS_LOW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_data(wd0), .wr_stb(wr0), .cts_in(cts0),
      .busy(busy0), .txd(txd0));
   // unqueued, one stop bit, active-high, 1000/100 = 10-cycle bits
   uart_cts_tx #(.CLK_HZ(1000), .BAUD_HZ(100), .BAUD_DIV(0), .STOP_BITS(1),
                 .FIFO_DEPTH(0), .CTS_MODE(CTS_HIGH)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_data(wd1), .wr_stb(wr1), .cts_in(cts1),
      .busy(busy1), .txd(txd1));
   // defaults: clear-to-send ignored, 8-cycle bits
   uart_cts_tx u2 (
      .clk(clk), .rst_n(rst_n), .wr_data(wd2), .wr_stb(wr2), .cts_in(cts2),
      .busy(busy2), .txd(txd2));

   function automatic logic line(input int w);
      case (w)
         0: return txd0;
         1: return txd1;
         default: return txd2;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input int w, input logic [7:0] b);
      case (w)
         0: begin wd0 = b; wr0 = 1'b1; end
         1: begin wd1 = b; wr1 = 1'b1; end
         default: begin wd2 = b; wr2 = 1'b1; end
      endcase
      @(negedge clk);
      wr0 = 1'b0; wr1 = 1'b0; wr2 = 1'b0;
   endtask

   task automatic decode(input int w, input int cpb, input int ns,
                         output logic [7:0] b, output bit good);
      int t;
      t = 0;
      good = 1'b1;
      b = '0;
      while (line(w) !== 1'b0) begin
         @(negedge clk);
         t++;
         if (t > 5000) begin good = 1'b0; return; end
      end
      repeat (cpb / 2) @(negedge clk);
      if (line(w) !== 1'b0) good = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (cpb) @(negedge clk);
         b[i] = line(w);
      end
      for (int s = 0; s < ns; s++) begin
         repeat (cpb) @(negedge clk);
         if (line(w) !== 1'b1) good = 1'b0;
      end
   endtask

   task automatic quiet(input int w, input int cycles, output bit stayed);
      stayed = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (line(w) !== 1'b1) stayed = 1'b0;
      end
   endtask

   function automatic logic [7:0] pick(input int i);
      return 8'((i * 37 + 11) ^ (i << 3));
   endfunction

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      bit good, q;
      logic [7:0] exp_q[$];
      void'($urandom(32'h1234_5678));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(txd0 && txd1 && txd2, "R1", {txd0, txd1, txd2}, 3'b111);
      chk(!busy0 && !busy1 && !busy2, "R6/R7 reset busy", {busy0, busy1, busy2}, 0);

      // R8 and R2: default instance, derived 8-cycle period, CTS ignored (R4)
      cts2 = 1'b1;
      put(2, 8'hC3);
      decode(2, 8, 1, got, good);
      chk(good && got == 8'hC3, "R2/R4 default", got, 8'hC3);

      // R6: flow stopped makes busy high, write dropped
      cts1 = 1'b0;
      @(negedge clk);
      chk(busy1 === 1'b1, "R6 busy on cts", busy1, 1);
      put(1, 8'h77);
      quiet(1, 150, q);
      chk(q, "R4/R6 dropped while stopped", q, 1);
      cts1 = 1'b1;
      @(negedge clk);
      chk(busy1 === 1'b0, "R6 busy clears", busy1, 0);

      // R8/R2: derived 10-cycle period, write during frame dropped (R6)
      put(1, 8'hA5);
      chk(busy1 === 1'b1, "R6 busy in frame", busy1, 1);
      fork
         decode(1, 10, 1, got, good);
         begin repeat (20) @(negedge clk); put(1, 8'h3C); end
      join
      chk(good && got == 8'hA5, "R2/R8 frame", got, 8'hA5);
      quiet(1, 150, q);
      chk(q, "R6 busy write dropped", q, 1);

      // R5: clear-to-send withdrawn mid-frame
      put(1, 8'h5A);
      fork
         decode(1, 10, 1, got, good);
         begin repeat (30) @(negedge clk); cts1 = 1'b0; end
      join
      chk(good && got == 8'h5A, "R5 frame completes", got, 8'h5A);
      quiet(1, 40, q);
      chk(q && busy1 === 1'b1, "R5 idle after", {q, busy1}, 2'b11);
      cts1 = 1'b1;

      // R7/R4: fill queue with flow stopped (active low: 1 = stop)
      cts0 = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         chk(busy0 === 1'b0, "R7 not full", busy0, 0);
         put(0, pick(i));
      end
      chk(busy0 === 1'b1, "R7 full", busy0, 1);
      put(0, 8'hEE);
      quiet(0, 40, q);
      chk(q, "R4 active-low hold", q, 1);
      cts0 = 1'b0;
      for (int i = 0; i < 4; i++) begin
         decode(0, 8, 2, got, good);
         chk(good && got == pick(i), "R7/R3 order", got, pick(i));
      end
      quiet(0, 150, q);
      chk(q, "R7 full write dropped", q, 1);

      // random traffic through the queue, back-to-back frames test R3 gaps
      fork
         begin
            for (int i = 0; i < 24; i++) begin
               logic [7:0] b;
               while (busy0) @(negedge clk);
               b = 8'($urandom);
               exp_q.push_back(b);
               put(0, b);
               repeat ($urandom % 30) @(negedge clk);
            end
         end
         begin
            for (int i = 0; i < 24; i++) begin
               logic [7:0] e;
               logic [7:0] r;
               bit gd;
               decode(0, 8, 2, r, gd);
               e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
               chk(gd && r == e, "R2/R3/R7 random", r, e);
            end
         end
      join

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule